// File: doc/BRIEF.md
# Serial Port Register Front End with Delayed Interrupts

This block is the byte-wide register face of a serial port. A host reaches eight one-byte registers over a small bus with a 3-bit offset, separate read and write strobes, and 8-bit write and read data. Received bytes come in on a valid/ready pair, and transmitted bytes leave as a one-cycle strobe with data. A single interrupt line tells the host that a receive or transmit event needs service. Bit timing, baud generation and FIFOs are handled elsewhere. The divisor-latch window can be addressed, but it has no effect.

Receive and transmit interrupts are normally raised through two delay timers rather than at once. Each timer starts again from the beginning when it is retriggered. When a timer runs out, it raises its pending bit only if the matching enable is still set at that moment. A fresh receive byte that arrives while receive interrupts are enabled is the one exception: it raises receive-pending at once. Each timer is a small state machine with the states `TMR_IDLE` and `TMR_RUN`:

- Start: any state goes to `TMR_RUN` with a full interval loaded.
- Cancel: any state goes to `TMR_IDLE`.
- Count-out: `TMR_RUN` goes to `TMR_IDLE` and gives a one-cycle expiry.
- Start has priority over cancel.

Top module: `uart_regif`

## Requirements
- R1: After reset, the enable, line-control and modem-control registers read 0x00. The identification register reads 0x01, the line-status register reads 0x60, and `irq` is low.
- R2: While line-control bit 7 is set, offsets 0 and 1 accept accesses but read 0x00. Writes there do not change the enable register, emit no transmit strobe and consume no receive byte. Line control at offset 3 reads back what was written.
- R3: A read of offset 0 with line-control bit 7 clear has these effects:
  - It returns `rx_data` when `rx_valid` is high, and 0x00 otherwise.
  - It drives `rx_ready` high in that cycle only if a byte is present.
  - It clears receive-pending.
- R4: A write of offset 0 with line-control bit 7 clear has these effects:
  - One cycle later it raises `tx_strobe` for one cycle, with the byte on `tx_data`.
  - It clears transmit-pending.
  - It starts the transmit timer when enable bit 1 is set.
- R5: Offset 1 (line-control bit 7 clear) is the enable register and reads back as written. Bit 1 is the transmit enable and bit 0 is the receive enable.
  - Writing bit 1 set starts the transmit timer. Writing it clear cancels the timer and clears transmit-pending.
  - Writing bit 0 set while a byte is present starts the receive timer. Any other write cancels the receive timer and clears receive-pending.
- R6: A pending bit rises exactly DELAY cycles after its timer is triggered. Retriggering a running timer restarts the full interval.
- R7: A timer expiry sets its pending bit only if the matching enable bit is set at that moment. Otherwise the expiry is dropped.
- R8: A rising edge of `rx_valid` while enable bit 0 is set raises receive-pending on the next clock edge, with no delay.
- R9: A read of offset 2 returns one of three codes:
  - 0x04 while receive is pending, which has priority;
  - otherwise 0x02 while transmit is pending;
  - otherwise 0x01.
  Every such read clears transmit-pending.
- R10: Offset 5 reads 0x60 (bit 6 transmitter empty, bit 5 holding register empty). Bit 0 (data ready) is added while `rx_valid` is high.
- R11: Offsets 6 and 7 read 0x00, and writes to offsets 2 and 7 are ignored. Writing 0x1A to offset 4 latches 0x9A there, and offset 4 ignores any other value written to it.
- R12: `irq` is high exactly when receive-pending or transmit-pending is set.
- R13: After a data read in which receive is enabled and `rx_valid` is still high in the next cycle, the receive timer starts in that next cycle. Receive-pending therefore rises DELAY+1 cycles after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and state |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Received byte consumed this cycle |
| tx_strobe | output | 1 | Transmit byte valid for one cycle |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
Several rules are checked on every cycle:
- each pending bit is only ever held with its enable set;
- an identification read leaves transmit-pending clear;
- a data read leaves receive-pending clear;
- a receive arrival with enable set raises receive-pending;
- a transmit strobe always follows a data-port write;
- a timer never expires right after a start or a lone cancel.

Other behaviour only the bench scenarios can show. This covers the exact delay length and its restart, the dropped expiry when a data read and a disable meet, the receive-over-transmit priority of the identification codes, the modem-control latch value, and the divisor-window side effects that must not happen.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_IER  = 3'd1;
    localparam logic [2:0] OFF_IIR  = 3'd2;
    localparam logic [2:0] OFF_LCR  = 3'd3;
    localparam logic [2:0] OFF_MCR  = 3'd4;
    localparam logic [2:0] OFF_LSR  = 3'd5;

    localparam int unsigned SRC_RX = 0;
    localparam int unsigned SRC_TX = 1;
    localparam int unsigned NSRC   = 2;

    localparam int unsigned LCR_WINDOW_BIT = 7;

    localparam logic [7:0] ID_RX   = 8'h04;
    localparam logic [7:0] ID_TX   = 8'h02;
    localparam logic [7:0] ID_NONE = 8'h01;

    localparam logic [7:0] LSR_IDLE_BITS = 8'h60;
    localparam logic [7:0] MCR_TRIGGER   = 8'h1A;
    localparam logic [7:0] MCR_LATCHED   = 8'h9A;

endpackage

// File: rtl/uart_regif_timer.sv
module uart_regif_timer #(
    parameter int unsigned DELAY = 450
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic expire
);
    import uart_regif_pkg::*;

    localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

    tmr_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            TMR_IDLE: cnt_d = cnt_q;
            TMR_RUN: begin
                if (cnt_q == '0) st_d = TMR_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
        endcase
        if (cancel) st_d = TMR_IDLE;
        if (start) begin
            st_d  = TMR_RUN;
            cnt_d = LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        expire = (st_q == TMR_RUN) && (cnt_q == '0);
    end

    generate
        if (DELAY > 1) begin : g_chk_early
            AST_TMR_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> !expire); // R6
        end
    endgenerate

    AST_TMR_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && !start) |=> !expire); // R5

endmodule

// File: rtl/uart_regif_rdmux.sv
module uart_regif_rdmux (
    input  logic [2:0] addr,
    input  logic       window,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic [7:0] ier,
    input  logic [7:0] lcr,
    input  logic [7:0] mcr,
    input  logic       rx_pend,
    input  logic       tx_pend,
    output logic [7:0] rdata
);
    import uart_regif_pkg::*;

    logic [7:0] id_code;

    always_comb begin
        if (rx_pend)      id_code = ID_RX;
        else if (tx_pend) id_code = ID_TX;
        else              id_code = ID_NONE;
    end

    always_comb begin
        case (addr)
            OFF_DATA: rdata = (!window && rx_valid) ? rx_data : 8'h00;
            OFF_IER:  rdata = window ? 8'h00 : ier;
            OFF_IIR:  rdata = id_code;
            OFF_LCR:  rdata = lcr;
            OFF_MCR:  rdata = mcr;
            OFF_LSR:  rdata = LSR_IDLE_BITS | {7'd0, rx_valid};
            default:  rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/uart_regif.sv
module uart_regif #(
    parameter int unsigned DELAY = 450
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       tx_strobe,
    output logic [7:0] tx_data,
    output logic       irq
);
    import uart_regif_pkg::*;

    logic [7:0] ier_q, lcr_q, mcr_q, tx_data_q;
    logic       rx_pend_q, tx_pend_q, rx_valid_q, data_rd_q, tx_strobe_q;
    logic       window;
    logic       data_rd, data_wr, ier_wr, iir_rd, lcr_wr, mcr_wr, arrival, rx_keep;
    logic       rx_set, rx_clr, tx_set, tx_clr;
    logic [NSRC-1:0] t_start, t_cancel, t_expire;

    assign window  = lcr_q[LCR_WINDOW_BIT];
    assign data_rd = bus_rd && (bus_addr == OFF_DATA) && !window;
    assign data_wr = bus_wr && (bus_addr == OFF_DATA) && !window;
    assign ier_wr  = bus_wr && (bus_addr == OFF_IER) && !window;
    assign iir_rd  = bus_rd && (bus_addr == OFF_IIR);
    assign lcr_wr  = bus_wr && (bus_addr == OFF_LCR);
    assign mcr_wr  = bus_wr && (bus_addr == OFF_MCR);
    assign arrival = rx_valid && !rx_valid_q;
    assign rx_keep = ier_wr && bus_wdata[SRC_RX] && rx_valid;

    always_comb begin
        t_start[SRC_TX]  = (data_wr && ier_q[SRC_TX]) || (ier_wr && bus_wdata[SRC_TX]);
        t_cancel[SRC_TX] = ier_wr && !bus_wdata[SRC_TX];
        t_start[SRC_RX]  = rx_keep || (data_rd_q && rx_valid && ier_q[SRC_RX]);
        t_cancel[SRC_RX] = ier_wr && !rx_keep;
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_tmr
            uart_regif_timer #(.DELAY(DELAY)) u_tmr (
                .clk    (clk),
                .rst_n  (rst_n),
                .start  (t_start[g]),
                .cancel (t_cancel[g]),
                .expire (t_expire[g])
            );
        end
    endgenerate

    always_comb begin
        tx_set = t_expire[SRC_TX] && ier_q[SRC_TX];
        tx_clr = data_wr || iir_rd || t_cancel[SRC_TX];
        rx_set = (t_expire[SRC_RX] || arrival) && ier_q[SRC_RX];
        rx_clr = data_rd || t_cancel[SRC_RX];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q       <= '0;
            lcr_q       <= '0;
            mcr_q       <= '0;
            tx_data_q   <= '0;
            tx_strobe_q <= 1'b0;
            rx_pend_q   <= 1'b0;
            tx_pend_q   <= 1'b0;
            rx_valid_q  <= 1'b0;
            data_rd_q   <= 1'b0;
        end else begin
            if (ier_wr) ier_q <= bus_wdata;
            if (lcr_wr) lcr_q <= bus_wdata;
            if (mcr_wr && bus_wdata == MCR_TRIGGER) mcr_q <= MCR_LATCHED;
            if (data_wr) tx_data_q <= bus_wdata;
            tx_strobe_q <= data_wr;
            rx_valid_q  <= rx_valid;
            data_rd_q   <= data_rd;
            if (tx_clr)      tx_pend_q <= 1'b0;
            else if (tx_set) tx_pend_q <= 1'b1;
            if (rx_clr)      rx_pend_q <= 1'b0;
            else if (rx_set) rx_pend_q <= 1'b1;
        end
    end

    uart_regif_rdmux u_rdmux (
        .addr     (bus_addr),
        .window   (window),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .ier      (ier_q),
        .lcr      (lcr_q),
        .mcr      (mcr_q),
        .rx_pend  (rx_pend_q),
        .tx_pend  (tx_pend_q),
        .rdata    (bus_rdata)
    );

    assign rx_ready  = data_rd && rx_valid;
    assign tx_strobe = tx_strobe_q;
    assign tx_data   = tx_data_q;
    assign irq       = rx_pend_q || tx_pend_q;

    AST_TXPEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pend_q |-> ier_q[SRC_TX]); // R7
    AST_RXPEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pend_q |-> ier_q[SRC_RX]); // R7
    AST_ID_READ_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_IIR) |=> !tx_pend_q); // R9
    AST_DATA_READ_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_DATA && !lcr_q[LCR_WINDOW_BIT]) |=> !irq || tx_pend_q); // R3
    AST_ARRIVAL_SETS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_valid) && ier_q[SRC_RX] && !bus_rd && !bus_wr) |=> rx_pend_q); // R8
    AST_TX_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(bus_wr && bus_addr == OFF_DATA)); // R4

endmodule

// File: tb/uart_regif_bench.sv
module uart_regif_bench;
    localparam int unsigned DELAY = 450;
    localparam int NV = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, tx_strobe, irq;
    logic [7:0] tx_data;

    int total = 0;
    int bad = 0;
    int tx_cnt = 0;
    logic [7:0] tx_last = '0;

    always #5 clk = ~clk;

    uart_regif #(.DELAY(DELAY)) u_uart_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_strobe(tx_strobe), .tx_data(tx_data), .irq(irq)
    );

    always @(negedge clk) if (tx_strobe) begin
        tx_cnt++;
        tx_last = tx_data;
    end

    // {wr, addr, wdata, expected, requirement id}
    localparam logic [23:0] VEC [0:NV-1] = '{
        {1'b1, 3'd3, 8'h83, 8'h00, 4'd2},
        {1'b1, 3'd0, 8'h55, 8'h00, 4'd2},
        {1'b1, 3'd1, 8'hFF, 8'h00, 4'd2},
        {1'b0, 3'd0, 8'h00, 8'h00, 4'd2},
        {1'b0, 3'd1, 8'h00, 8'h00, 4'd2},
        {1'b0, 3'd3, 8'h00, 8'h83, 4'd2},
        {1'b1, 3'd3, 8'h03, 8'h00, 4'd2},
        {1'b0, 3'd1, 8'h00, 8'h00, 4'd2},
        {1'b0, 3'd3, 8'h00, 8'h03, 4'd2},
        {1'b1, 3'd4, 8'h1A, 8'h00, 4'd11},
        {1'b0, 3'd4, 8'h00, 8'h9A, 4'd11},
        {1'b1, 3'd4, 8'h05, 8'h00, 4'd11},
        {1'b0, 3'd4, 8'h00, 8'h9A, 4'd11},
        {1'b1, 3'd7, 8'h33, 8'h00, 4'd11},
        {1'b0, 3'd7, 8'h00, 8'h00, 4'd11},
        {1'b0, 3'd6, 8'h00, 8'h00, 4'd11},
        {1'b1, 3'd2, 8'hC7, 8'h00, 4'd11},
        {1'b0, 3'd2, 8'h00, 8'h01, 4'd9},
        {1'b0, 3'd5, 8'h00, 8'h60, 4'd10},
        {1'b0, 3'd0, 8'h00, 8'h00, 4'd3}
    };

    function automatic string req_name(input logic [3:0] id);
        case (id)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d, output logic rdy);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata; rdy = rx_ready;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    initial begin
        #(10 * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1", {7'd0, irq}, 8'h00);
        bus_read(3'd1, d, r); chk("R1", d, 8'h00);
        bus_read(3'd3, d, r); chk("R1", d, 8'h00);
        bus_read(3'd4, d, r); chk("R1", d, 8'h00);
        bus_read(3'd2, d, r); chk("R1", d, 8'h01);
        bus_read(3'd5, d, r); chk("R1", d, 8'h60);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][23]) bus_write(VEC[i][22:20], VEC[i][19:12]);
            else begin
                bus_read(VEC[i][22:20], d, r);
                chk(req_name(VEC[i][3:0]), d, VEC[i][11:4]);
            end
        end
        chk("R2", tx_cnt[7:0], 8'd0);

        // R4 transmit
        bus_write(3'd0, 8'hA5);
        repeat (2) @(posedge clk); #1;
        chk("R4", tx_cnt[7:0], 8'd1);
        chk("R4", tx_last, 8'hA5);

        // R6 / R12 transmit delay
        bus_write(3'd1, 8'h02);
        repeat (DELAY - 1) @(posedge clk); #1;
        chk("R6", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        chk("R12", {7'd0, irq}, 8'h01);
        bus_read(3'd2, d, r); chk("R9", d, 8'h02);
        chk("R9", {7'd0, irq}, 8'h00);
        bus_read(3'd2, d, r); chk("R9", d, 8'h01);
        bus_read(3'd1, d, r); chk("R5", d, 8'h02);

        // R6 restart by data write
        bus_write(3'd1, 8'h02);
        repeat (100) @(posedge clk);
        bus_write(3'd0, 8'h11);
        repeat (DELAY - 1) @(posedge clk); #1;
        chk("R6", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        chk("R6", {7'd0, irq}, 8'h01);
        bus_read(3'd2, d, r);

        // R5 disable cancels
        bus_write(3'd1, 8'h02);
        repeat (50) @(posedge clk);
        bus_write(3'd1, 8'h00);
        repeat (DELAY + 10) @(posedge clk); #1;
        chk("R5", {7'd0, irq}, 8'h00);

        // R8 immediate arrival
        bus_write(3'd1, 8'h01);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h3C;
        @(posedge clk); #1;
        chk("R8", {7'd0, irq}, 8'h01);
        bus_read(3'd5, d, r); chk("R10", d, 8'h61);
        bus_read(3'd2, d, r); chk("R9", d, 8'h04);

        // R3 read with more data waiting, R13 restart
        bus_read(3'd0, d, r);
        rx_data = 8'h4D;
        chk("R3", d, 8'h3C);
        chk("R3", {7'd0, r}, 8'h01);
        chk("R3", {7'd0, irq}, 8'h00);
        repeat (DELAY) @(posedge clk); #1;
        chk("R13", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        chk("R13", {7'd0, irq}, 8'h01);

        // R9 priority, transmit cleared by identification read
        bus_write(3'd1, 8'h03);
        repeat (DELAY + 2) @(posedge clk);
        bus_read(3'd2, d, r); chk("R9", d, 8'h04);
        bus_read(3'd0, d, r);
        rx_valid = 1'b0;
        chk("R3", d, 8'h4D);
        bus_read(3'd2, d, r); chk("R9", d, 8'h01);
        bus_read(3'd0, d, r);
        chk("R3", d, 8'h00);
        chk("R3", {7'd0, r}, 8'h00);

        // R7 expiry dropped when disabled as the timer starts
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5E;
        @(posedge clk); #1;
        bus_read(3'd0, d, r);
        rx_data = 8'h6F;
        bus_write(3'd1, 8'h00);
        repeat (DELAY + 10) @(posedge clk); #1;
        chk("R7", {7'd0, irq}, 8'h00);
        bus_read(3'd2, d, r); chk("R7", d, 8'h01);

        // R1 reset mid-run
        bus_write(3'd1, 8'h03);
        bus_write(3'd3, 8'h80);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        chk("R1", {7'd0, irq}, 8'h00);
        bus_read(3'd3, d, r); chk("R1", d, 8'h00);
        bus_read(3'd1, d, r); chk("R1", d, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule